// File: doc/BRIEF.md
# Streaming Integral Image Generator

This block consumes a raster stream of 12-bit colour pixels, turns each one into an 8-bit luminance value, and builds the summed-area table of a fixed window (39 columns by 59 rows by default) in a single pass. Each stored entry holds the sum of all luminance values above and to the left of its position, that position included. Downstream window classifiers can then read the sum of any rectangle with four reads.

A frame opens with a start-of-frame marker on its first pixel, and each line closes with an end-of-line marker. Pixels outside the window are dropped: extra columns, extra rows, anything after the window is complete, and anything before the first start-of-frame. A one-cycle done pulse tells the classifier stage that the table is complete and scanning may begin. The table is read through a synchronous port with an address input and a data output.

Top module: `integral_gen`

## Requirements
- R1: Luminance is computed from `pix_rgb` with red in bits 11:8, green in 7:4 and blue in 3:0. Each 4-bit field c is widened to 8 bits as c*17. Luminance = (77*R8 + 150*G8 + 29*B8) >> 8, saturated to 255. White gives 255 and black gives 0.
- R2: After a frame, the entry at address y*W + x holds the sum of the luminance of every window pixel (i, j) with i <= x and j <= y, where x is the column and y the row.
- R3: Entries are SUM_W = 20 bits wide. With the default 39 x 59 window and an all-white frame, the last entry is 586755, row 0 column 38 is 9945, and row 1 column 0 is 510.
- R4: After `pix_eol` the column returns to 0 and the row sum restarts. A line longer than W changes no entry with its extra pixels.
- R5: A valid pixel with `pix_sof` set is treated as column 0, row 0 of a new frame, even in the middle of a frame.
- R6: `rd_data` shows the entry at the `rd_addr` value sampled on the previous rising clock edge. The read latency is one cycle.
- R7: `done` is high for exactly one cycle. That cycle comes right after the clock edge that accepts the pixel at column W-1, row H-1.
- R8: Once the window is complete, and after reset until the first start-of-frame, valid pixels without `pix_sof` change no entry and raise no `done`.
- R9: While `pix_valid` is low, the values on `pix_sof`, `pix_eol` and `pix_rgb` have no effect.
- R10: While `rst_n` is low at a clock edge, `done` goes low. Stored entries are not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_sof | input | 1 | First pixel of a frame |
| pix_eol | input | 1 | Last pixel of a line |
| pix_rgb | input | 12 | Pixel colour, 4 bits per channel |
| rd_addr | input | AW = $clog2(W*H) | Table read address, row-major |
| rd_data | output | SUM_W | Table entry, one cycle after the address |
| done | output | 1 | One-cycle pulse when the table is complete |

## Verification
The assertions check on every cycle the properties that hold locally. A white or black pixel gives the extreme luminance. No write goes outside the table or happens during a stall. The window origin stores exactly its own luminance. `done` is a single-cycle pulse, and no write follows it without a new start-of-frame. The full integral values, the exact cycle of `done`, the read latency, and the handling of overlong lines, mid-frame restarts and reset can be shown only by the bench. The bench sweeps all 4096 colours, runs patterned frames with and without stalls in a small window, and sends one all-white frame through the default-size window.

// File: rtl/integral_pkg.sv
// Shared constants and types for the integral image generator.
package integral_pkg;
    localparam int RGB_W  = 12;
    localparam int CH_W   = 4;
    localparam int GRAY_W = 8;
    localparam int WGT_R  = 77;
    localparam int WGT_G  = 150;
    localparam int WGT_B  = 29;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb444_t;
endpackage

// File: rtl/ii_gray_conv.sv
// Converts a 4:4:4 colour pixel to 8-bit luminance, purely combinationally.
// Assumes the weights add up to 256, so the shift by 8 normalises the result.
module ii_gray_conv
    import integral_pkg::*;
(
    input  logic [RGB_W-1:0]  rgb_in,
    output logic [GRAY_W-1:0] gray_out
);
    rgb444_t     px;
    logic [7:0]  r8, g8, b8;
    logic [16:0] wsum;

    // Widen each channel by bit replication and form the weighted sum.
    always_comb begin
        px       = rgb444_t'(rgb_in);
        r8       = {px.r, px.r};
        g8       = {px.g, px.g};
        b8       = {px.b, px.b};
        wsum     = 17'(r8) * 17'(WGT_R) + 17'(g8) * 17'(WGT_G) + 17'(b8) * 17'(WGT_B);
        gray_out = wsum[16] ? 8'hFF : wsum[15:8];
    end
endmodule

// File: rtl/ii_raster_tracker.sv
// Follows the raster position from the start-of-frame and end-of-line markers.
// Decides which pixels fall inside the W x H window and flags the last one.
// Assumes pix_sof comes with the first valid pixel of a frame.
module ii_raster_tracker #(
    parameter int W  = 39,
    parameter int H  = 59,
    parameter int XW = $clog2(W + 1),
    parameter int YW = $clog2(H + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_valid,
    input  logic          pix_sof,
    input  logic          pix_eol,
    output logic          accept,
    output logic          last,
    output logic [XW-1:0] x_cur,
    output logic [YW-1:0] y_cur
);
    localparam logic [XW-1:0] W_L    = XW'(W);
    localparam logic [XW-1:0] W_LAST = XW'(W - 1);
    localparam logic [YW-1:0] H_L    = YW'(H);
    localparam logic [YW-1:0] H_LAST = YW'(H - 1);

    logic [XW-1:0] x_q;
    logic [YW-1:0] y_q;
    logic          armed_q;
    logic          start, live;

    // Current position, with a start-of-frame forcing the origin.
    always_comb begin
        start  = pix_valid & pix_sof;
        live   = start | armed_q;
        x_cur  = start ? '0 : x_q;
        y_cur  = start ? '0 : y_q;
        accept = pix_valid & live & (x_cur < W_L) & (y_cur < H_L);
        last   = accept & (x_cur == W_LAST) & (y_cur == H_LAST);
    end

    // Move the position forward on each live pixel and arm or disarm the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q     <= '0;
            y_q     <= '0;
            armed_q <= 1'b0;
        end else if (pix_valid && live) begin
            if (start) armed_q <= 1'b1;
            if (last)  armed_q <= 1'b0;
            if (pix_eol) begin
                x_q <= '0;
                y_q <= (y_cur < H_L) ? y_cur + 1'b1 : y_cur;
            end else begin
                x_q <= (x_cur < W_L) ? x_cur + 1'b1 : x_cur;
                y_q <= y_cur;
            end
        end
    end
endmodule

// File: rtl/ii_row_accum.sv
// Keeps the running sum of the current row and a one-row buffer of integral values.
// It produces ii(x,y) = rowsum(x,y) + ii(x,y-1), with row 0 taking zero from above.
// Assumes x < W whenever accept is high.
module ii_row_accum
    import integral_pkg::*;
#(
    parameter int W     = 39,
    parameter int XW    = $clog2(W + 1),
    parameter int YW    = 6,
    parameter int SUM_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [XW-1:0]     x_cur,
    input  logic [YW-1:0]     y_cur,
    input  logic [GRAY_W-1:0] gray,
    output logic [SUM_W-1:0]  ii_val
);
    localparam logic [XW-1:0] W_L = XW'(W);

    logic [SUM_W-1:0] row_q;
    logic [SUM_W-1:0] row_sum;
    logic [SUM_W-1:0] above;
    logic [XW-1:0]    idx;
    logic [SUM_W-1:0] line_q [W];

    // Combine the row sum with the stored value from the row above.
    always_comb begin
        idx     = (x_cur < W_L) ? x_cur : '0;
        row_sum = ((x_cur == '0) ? '0 : row_q) + SUM_W'(gray);
        above   = (y_cur == '0) ? '0 : line_q[idx];
        ii_val  = row_sum + above;
    end

    // Hold the running row sum between pixels.
    always_ff @(posedge clk) begin
        if (!rst_n) row_q <= '0;
        else if (accept) row_q <= row_sum;
    end

    // Replace the row-above entry for this column with the new integral value.
    always_ff @(posedge clk) begin
        if (accept) line_q[idx] <= ii_val;
    end
endmodule

// File: rtl/ii_store.sv
// Storage for the integral table, with one write port and a registered read port.
// Addresses at or above DEPTH read as zero.
module ii_store #(
    parameter int DEPTH = 2301,
    parameter int AW    = $clog2(DEPTH),
    parameter int SUM_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [SUM_W-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [SUM_W-1:0] rd_data
);
    logic [SUM_W-1:0] mem [DEPTH];

    // Write the integral value of an accepted pixel.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Register the read with a latency of one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else if (int'(rd_addr) < DEPTH) rd_data <= mem[rd_addr];
        else rd_data <= '0;
    end
endmodule

// File: rtl/integral_gen.sv
// Top of the streaming integral image generator.
// Converts each pixel to luminance, accumulates the summed-area table of a
// W x H window in one pass, stores it row-major and pulses done when it is complete.
// Assumes one pixel per cycle at most and a frame that opens with pix_sof.
module integral_gen
    import integral_pkg::*;
#(
    parameter int  W     = 39,
    parameter int  H     = 59,
    parameter int  SUM_W = 20,
    localparam int DEPTH = W * H,
    localparam int AW    = $clog2(DEPTH),
    localparam int XW    = $clog2(W + 1),
    localparam int YW    = $clog2(H + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    input  logic             pix_sof,
    input  logic             pix_eol,
    input  logic [11:0]      pix_rgb,
    input  logic [AW-1:0]    rd_addr,
    output logic [SUM_W-1:0] rd_data,
    output logic             done
);
    logic              wr_en;
    logic              last_px;
    logic [XW-1:0]     trk_x;
    logic [YW-1:0]     trk_y;
    logic [GRAY_W-1:0] gray;
    logic [SUM_W-1:0]  ii_val;
    logic [AW-1:0]     wr_addr;

    ii_gray_conv u_gray (
        .rgb_in   (pix_rgb),
        .gray_out (gray)
    );

    ii_raster_tracker #(.W(W), .H(H), .XW(XW), .YW(YW)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_valid (pix_valid),
        .pix_sof   (pix_sof),
        .pix_eol   (pix_eol),
        .accept    (wr_en),
        .last      (last_px),
        .x_cur     (trk_x),
        .y_cur     (trk_y)
    );

    ii_row_accum #(.W(W), .XW(XW), .YW(YW), .SUM_W(SUM_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (wr_en),
        .x_cur  (trk_x),
        .y_cur  (trk_y),
        .gray   (gray),
        .ii_val (ii_val)
    );

    // Row-major table address of the current pixel.
    always_comb wr_addr = AW'(trk_y) * AW'(W) + AW'(trk_x);

    ii_store #(.DEPTH(DEPTH), .AW(AW), .SUM_W(SUM_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (ii_val),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // Raise done for one cycle after the last window pixel is written.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else done <= last_px;
    end
endmodule

// File: rtl/integral_gen_chk.sv
// Assertion checker for integral_gen, attached with bind.
module integral_gen_chk #(
    parameter int  W     = 39,
    parameter int  H     = 59,
    parameter int  SUM_W = 20,
    localparam int DEPTH = W * H,
    localparam int AW    = $clog2(DEPTH),
    localparam int XW    = $clog2(W + 1),
    localparam int YW    = $clog2(H + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_valid,
    input logic             pix_sof,
    input logic [11:0]      pix_rgb,
    input logic [7:0]       gray,
    input logic             wr_en,
    input logic [AW-1:0]    wr_addr,
    input logic [SUM_W-1:0] wr_data,
    input logic [XW-1:0]    wr_x,
    input logic [YW-1:0]    wr_y,
    input logic             done
);
    assert_gray_white_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_rgb == 12'hFFF) |-> (gray == 8'd255));

    assert_gray_black_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_rgb == 12'h000) |-> (gray == 8'd0));

    assert_wr_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < DEPTH));

    assert_origin_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_x == '0 && wr_y == '0) |-> (wr_data == SUM_W'(gray)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_quiet_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(pix_valid && pix_sof)) |-> !wr_en);

    assert_stall_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> !wr_en);
endmodule

bind integral_gen integral_gen_chk #(.W(W), .H(H), .SUM_W(SUM_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_valid (pix_valid),
    .pix_sof   (pix_sof),
    .pix_rgb   (pix_rgb),
    .gray      (gray),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (ii_val),
    .wr_x      (trk_x),
    .wr_y      (trk_y),
    .done      (done)
);

// File: tb/tb_integral_gen.sv
`timescale 1ns/1ps
module tb_integral_gen;
    localparam int SW = 5;
    localparam int SH = 4;
    localparam int SD = SW * SH;
    localparam int SAW = $clog2(SD);
    localparam int FW = 39;
    localparam int FH = 59;
    localparam int FAW = $clog2(FW * FH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    // Small window instance
    logic v = 0, sof = 0, eol = 0;
    logic [11:0] rgb = '0;
    logic [SAW-1:0] ra = '0;
    logic [19:0] rd;
    logic done;

    integral_gen #(.W(SW), .H(SH)) dut (
        .clk(clk), .rst_n(rst_n), .pix_valid(v), .pix_sof(sof), .pix_eol(eol),
        .pix_rgb(rgb), .rd_addr(ra), .rd_data(rd), .done(done)
    );

    // Default size instance
    logic fv = 0, fsof = 0, feol = 0;
    logic [11:0] frgb = '0;
    logic [FAW-1:0] fra = '0;
    logic [19:0] frd;
    logic fdone;

    integral_gen dut_full (
        .clk(clk), .rst_n(rst_n), .pix_valid(fv), .pix_sof(fsof), .pix_eol(feol),
        .pix_rgb(frgb), .rd_addr(fra), .rd_data(frd), .done(fdone)
    );

    int checks = 0, fails = 0;
    int cyc = 0, done_cnt = 0, done_cyc = -1, fdone_cnt = 0;
    int last_cyc = 0;
    int ii_m [SD];
    bit finished = 0;

    always @(posedge clk) begin
        if (done) begin
            done_cnt <= done_cnt + 1;
            done_cyc <= cyc;
        end
        if (fdone) fdone_cnt <= fdone_cnt + 1;
        cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int gray_of(input logic [11:0] c);
        int r8, g8, b8, s;
        r8 = int'(c[11:8]) * 17;
        g8 = int'(c[7:4]) * 17;
        b8 = int'(c[3:0]) * 17;
        s = (77 * r8 + 150 * g8 + 29 * b8) / 256;
        return (s > 255) ? 255 : s;
    endfunction

    function automatic logic [11:0] rgb_of(input int x, input int y, input int seed);
        return 12'(x * 37 + y * 101 + seed * 13 + x * y * 7 + seed * x * 5 + seed * seed * 3);
    endfunction

    // Reference table for a frame, from the summed-area definition.
    task automatic model_frame(input int seed);
        for (int y = 0; y < SH; y++) begin
            int rs = 0;
            for (int x = 0; x < SW; x++) begin
                rs += gray_of(rgb_of(x, y, seed));
                ii_m[y * SW + x] = rs + ((y > 0) ? ii_m[(y - 1) * SW + x] : 0);
            end
        end
    endtask

    task automatic pix(input logic s, input logic e, input logic [11:0] c);
        @(negedge clk);
        v = 1; sof = s; eol = e; rgb = c;
    endtask

    // Stall cycle with garbage on the qualified inputs (R9).
    task automatic idle();
        @(negedge clk);
        v = 0; sof = 1; eol = 1; rgb = 12'hFFF;
    endtask

    task automatic send_frame(input int seed, input bit gaps, input int xcols, input int xrows);
        for (int y = 0; y < SH + xrows; y++) begin
            for (int x = 0; x < SW + xcols; x++) begin
                logic [11:0] c;
                if (gaps && ((x + y) % 3 == 1)) idle();
                c = (x < SW && y < SH) ? rgb_of(x, y, seed) : 12'hFFF;
                pix(x == 0 && y == 0, x == SW + xcols - 1, c);
                if (x == SW - 1 && y == SH - 1) last_cyc = cyc;
            end
        end
        repeat (3) idle();
    endtask

    // Pipelined reads: each value is checked one cycle after its address (R6).
    task automatic read_all(input string req);
        for (int a = 0; a <= SD; a++) begin
            @(negedge clk);
            if (a > 0) chk(rd == 20'(ii_m[a - 1]), req, int'(rd), ii_m[a - 1]);
            if (a < SD) ra = SAW'(a);
        end
    endtask

    task automatic frame_test(input int seed, input bit gaps, input int xcols, input int xrows, input string req);
        int d0;
        d0 = done_cnt;
        model_frame(seed);
        send_frame(seed, gaps, xcols, xrows);
        chk(done_cnt == d0 + 1, "R7 done pulse count", done_cnt - d0, 1);
        chk(done_cyc == last_cyc + 1, "R7 done timing", done_cyc, last_cyc + 1);
        read_all(req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R10 reset done", int'(done), 0);
        chk(fdone == 1'b0, "R10 reset done full", int'(fdone), 0);
        rst_n = 1;

        // R1: every colour as a one-pixel frame, read back at the origin.
        for (int c = 0; c < 4096; c++) begin
            pix(1'b1, 1'b0, 12'(c));
            @(negedge clk);
            v = 0; ra = '0;
            @(negedge clk);
            chk(rd == 20'(gray_of(12'(c))), "R1 gray", int'(rd), gray_of(12'(c)));
        end

        frame_test(1, 1'b0, 0, 0, "R2 integral");
        frame_test(2, 1'b1, 0, 0, "R9 stalled frame");
        frame_test(3, 1'b1, 2, 2, "R4 R8 long lines and extra rows");

        // R5: a partial frame is cut short by a new start-of-frame.
        for (int y = 0; y < 2; y++)
            for (int x = 0; x < SW; x++)
                pix(x == 0 && y == 0, x == SW - 1, rgb_of(x, y, 9));
        frame_test(4, 1'b0, 0, 0, "R5 restart");

        // R10 then R8: reset keeps the table, and pixels before a start-of-frame are ignored.
        begin
            int d0;
            @(negedge clk); rst_n = 0; v = 0;
            repeat (2) @(negedge clk);
            chk(done == 1'b0, "R10 done in reset", int'(done), 0);
            rst_n = 1;
            d0 = done_cnt;
            for (int y = 0; y < SH; y++)
                for (int x = 0; x < SW; x++)
                    pix(1'b0, x == SW - 1, 12'hFFF);
            repeat (3) idle();
            chk(done_cnt == d0, "R8 no done before sof", done_cnt - d0, 0);
            read_all("R8 R10 table kept");
        end

        // R3: all-white frame through the default-size window.
        for (int y = 0; y < FH; y++)
            for (int x = 0; x < FW; x++) begin
                @(negedge clk);
                fv = 1; fsof = (x == 0 && y == 0); feol = (x == FW - 1); frgb = 12'hFFF;
            end
        @(negedge clk); fv = 0;
        chk(fdone == 1'b1, "R7 full done", int'(fdone), 1);
        fra = FAW'(FW - 1);
        @(negedge clk); fra = FAW'(FW);
        chk(frd == 20'd9945, "R3 row 0 end", int'(frd), 9945);
        @(negedge clk); fra = FAW'(FW * FH - 1);
        chk(frd == 20'd510, "R3 row 1 start", int'(frd), 510);
        @(negedge clk);
        chk(frd == 20'd586755, "R3 last entry", int'(frd), 586755);
        chk(fdone_cnt == 1, "R7 full pulse count", fdone_cnt, 1);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule